// File: doc/BRIEF.md
# Processor Low-Power Mode Sequencer

This block decides when a processor core may go into one of three low-power states, and when it must leave. A small configuration register holds an enable bit for each state: a light idle state, a deeper nap state and the deepest sleep state. Setting a power-down request bit starts entry into the state whose enable bit is set.

The light idle state is entered at once. Its PLL, time base and bus snooping all stay active. Nap and sleep turn bus snooping off, so the block first raises a quiesce request. It then waits for the system logic to acknowledge. After the acknowledge it counts a fixed number of clocks before it enters the state. This handshake is what keeps the caches coherent once snooping stops.

In nap the PLL and the time base keep running. In sleep the block raises a flag that lets system logic switch the PLL to bypass and then stop the system clock. A wake input brings the block back to the run state from any state. If no acknowledge arrives within a timeout, the block abandons the entry attempt.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, state_o is 0 (run), qreq and pd_pending are 0, pll_active, tbase_active and snoop_active are 1, and pll_bypass_ok is 0.
- R2: A one-cycle cfg_we pulse loads cfg_mode into the enable register: bit 0 enables doze, bit 1 enables nap and bit 2 enables sleep. If pd_set arrives while no enable bit is set, state_o stays 0. pd_pending reads 1 on the edge after pd_set and 0 on the edge after that.
- R3: When several enable bits are set, the priority is sleep, then nap, then doze.
- R4: With doze selected, state_o becomes 1 on the second edge after pd_set. qreq stays 0, and the PLL, time base and snoop flags all stay 1.
- R5: With nap or sleep selected, state_o becomes 2 (nap_wait) or 4 (sleep_wait) on the second edge after pd_set, and qreq is 1 from that edge onward.
- R6: The nap or sleep state is entered exactly ENTRY_DELAY (default 8) edges after the edge that first samples qack high. It is not entered earlier, and qack may drop during the delay.
- R7: In nap (state_o 3), snoop_active is 0, pll_active and tbase_active are 1, and qreq stays 1.
- R8: In sleep (state_o 5), pll_bypass_ok is 1 and pll_active, tbase_active and snoop_active are 0.
- R9: A wake pulse returns the block to state 0 on the next edge, from any state including the wait states. On that edge qreq and pd_pending are both 0.
- R10: If qack has not been seen ACK_TIMEOUT (default 64) edges after a wait state was entered, the block returns to state 0 with qreq and pd_pending cleared.
- R11: state_o encodes run=0, doze=1, nap_wait=2, nap=3, sleep_wait=4 and sleep=5, and never carries any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the mode-enable register |
| cfg_mode | input | 3 | Enable bits: bit 0 doze, bit 1 nap, bit 2 sleep |
| pd_set | input | 1 | Sets the power-down request bit |
| wake | input | 1 | Wake event; returns the block to run |
| qack | input | 1 | Quiesce acknowledge from the system logic |
| qreq | output | 1 | Quiesce request to the system logic |
| pd_pending | output | 1 | Current value of the power-down request bit |
| state_o | output | 3 | Encoded current state |
| pll_active | output | 1 | PLL domain stays running |
| tbase_active | output | 1 | Time base stays running |
| snoop_active | output | 1 | Bus snooping is active |
| pll_bypass_ok | output | 1 | System may bypass the PLL and stop the clock |

## Verification
The hardest case to reach is the acknowledge timeout. Nothing in a normal entry holds the block in a wait state for ACK_TIMEOUT cycles, so the bench selects nap and doze together, raises the request and then never drives qack. It samples the cycle just before the abort and the abort cycle itself. The entry delay gets a similar treatment: qack is pulsed for only a single cycle, which shows that the block latched the acknowledge and still enters exactly ENTRY_DELAY edges later.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_DOZE       = 3'd1,
        ST_NAP_WAIT   = 3'd2,
        ST_NAP        = 3'd3,
        ST_SLEEP_WAIT = 3'd4,
        ST_SLEEP      = 3'd5
    } pwr_state_e;

    localparam int unsigned MODE_W = 3;

    typedef struct packed {
        logic pll;
        logic tbase;
        logic snoop;
        logic bypass_ok;
        logic qreq;
    } dom_flags_t;
endpackage

// File: rtl/pwr_mode_pick.sv
module pwr_mode_pick
    import pwr_seq_pkg::*;
(
    input  logic [MODE_W-1:0] en,
    output pwr_state_e        target,
    output logic              any
);
    // Priority: sleep (bit 2) over nap (bit 1) over doze (bit 0)
    always_comb begin
        any    = |en;
        target = ST_RUN;
        if (en[2])      target = ST_SLEEP_WAIT;
        else if (en[1]) target = ST_NAP_WAIT;
        else if (en[0]) target = ST_DOZE;
    end
endmodule

// File: rtl/pwr_domain_map.sv
module pwr_domain_map
    import pwr_seq_pkg::*;
(
    input  pwr_state_e st,
    output dom_flags_t flags
);
    always_comb begin
        flags = '{pll: 1'b1, tbase: 1'b1, snoop: 1'b1, bypass_ok: 1'b0, qreq: 1'b0};
        unique case (st)
            ST_NAP_WAIT, ST_SLEEP_WAIT: flags.qreq = 1'b1;
            ST_NAP: begin
                flags.qreq  = 1'b1;
                flags.snoop = 1'b0;
            end
            ST_SLEEP: begin
                flags.qreq      = 1'b1;
                flags.snoop     = 1'b0;
                flags.pll       = 1'b0;
                flags.tbase     = 1'b0;
                flags.bypass_ok = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_seq_pkg::*;
#(
    parameter int unsigned ENTRY_DELAY = 8,
    parameter int unsigned ACK_TIMEOUT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_mode,
    input  logic       pd_set,
    input  logic       wake,
    input  logic       qack,
    output logic       qreq,
    output logic       pd_pending,
    output logic [2:0] state_o,
    output logic       pll_active,
    output logic       tbase_active,
    output logic       snoop_active,
    output logic       pll_bypass_ok
);
    localparam int unsigned MAX_CNT = (ENTRY_DELAY > ACK_TIMEOUT) ? ENTRY_DELAY : ACK_TIMEOUT;
    localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(ENTRY_DELAY - 1);
    localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(ACK_TIMEOUT - 1);

    typedef struct packed {
        pwr_state_e        st;
        logic [MODE_W-1:0] en;
        logic              pd;
        logic              acked;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t       seq_d, seq_q;
    pwr_state_e pick_target;
    logic       pick_any;
    dom_flags_t flags;

    pwr_mode_pick u_pick (
        .en     (seq_q.en),
        .target (pick_target),
        .any    (pick_any)
    );

    pwr_domain_map u_map (
        .st    (seq_q.st),
        .flags (flags)
    );

    always_comb begin
        seq_d = seq_q;
        if (cfg_we) seq_d.en = cfg_mode;
        if (pd_set) seq_d.pd = 1'b1;

        if (wake) begin
            seq_d.st    = ST_RUN;
            seq_d.pd    = 1'b0;
            seq_d.acked = 1'b0;
            seq_d.cnt   = '0;
        end else begin
            unique case (seq_q.st)
                ST_RUN: begin
                    if (seq_q.pd) begin
                        if (!pick_any) begin
                            seq_d.pd = pd_set;
                        end else begin
                            seq_d.st    = pick_target;
                            seq_d.acked = 1'b0;
                            seq_d.cnt   = '0;
                        end
                    end
                end
                ST_NAP_WAIT, ST_SLEEP_WAIT: begin
                    if (!seq_q.acked) begin
                        if (qack) begin
                            seq_d.acked = 1'b1;
                            seq_d.cnt   = '0;
                        end else if (seq_q.cnt == TO_LAST) begin
                            seq_d.st  = ST_RUN;
                            seq_d.pd  = 1'b0;
                            seq_d.cnt = '0;
                        end else begin
                            seq_d.cnt = seq_q.cnt + 1'b1;
                        end
                    end else if (seq_q.cnt == DLY_LAST) begin
                        seq_d.st    = (seq_q.st == ST_NAP_WAIT) ? ST_NAP : ST_SLEEP;
                        seq_d.acked = 1'b0;
                        seq_d.cnt   = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_RUN, en: '0, pd: 1'b0, acked: 1'b0, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o       = seq_q.st;
    assign pd_pending    = seq_q.pd;
    assign qreq          = flags.qreq;
    assign pll_active    = flags.pll;
    assign tbase_active  = flags.tbase;
    assign snoop_active  = flags.snoop;
    assign pll_bypass_ok = flags.bypass_ok;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wake,
    input logic       qreq,
    input logic       pd_pending,
    input logic [2:0] state_o,
    input logic [2:0] en_q
);
    // R9
    wake_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (state_o == 3'd0 && !qreq && !pd_pending));

    // R2
    idle_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && pd_pending && en_q == 3'b000) |=> state_o == 3'd0);

    // R4
    doze_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && pd_pending && en_q == 3'b001 && !wake) |=> state_o == 3'd1);

    // R6
    nap_entry_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && $past(state_o) != 3'd3) |-> $past(state_o) == 3'd2);

    // R8
    sleep_entry_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd5 && $past(state_o) != 3'd5) |-> $past(state_o) == 3'd4);

    // R10
    wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2) |=> (state_o inside {3'd0, 3'd2, 3'd3}));

    // R11
    state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd5);
endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake       (wake),
    .qreq       (qreq),
    .pd_pending (pd_pending),
    .state_o    (state_o),
    .en_q       (seq_q.en)
);

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_mode = 3'b000;
    logic       pd_set = 1'b0;
    logic       wake = 1'b0;
    logic       qack = 1'b0;
    logic       qreq, pd_pending, pll_active, tbase_active, snoop_active, pll_bypass_ok;
    logic [2:0] state_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [3:0] FL_UP    = 4'b1110; // {pll, tbase, snoop, bypass_ok}
    localparam logic [3:0] FL_NAP   = 4'b1100;
    localparam logic [3:0] FL_SLEEP = 4'b0001;

    typedef struct {
        int         at;
        logic [2:0] st;
        logic       qr;
        logic       pd;
        logic [3:0] fl;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk; // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    pwr_mode_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .pd_set(pd_set), .wake(wake), .qack(qack), .qreq(qreq),
        .pd_pending(pd_pending), .state_o(state_o), .pll_active(pll_active),
        .tbase_active(tbase_active), .snoop_active(snoop_active),
        .pll_bypass_ok(pll_bypass_ok)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(input int dc, input logic [2:0] st, input logic qr,
                             input logic pd, input logic [3:0] fl, input string tag);
        exp_t e;
        e.at = cyc + dc; e.st = st; e.qr = qr; e.pd = pd; e.fl = fl; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic write_cfg(input logic [2:0] m);
        cfg_we = 1'b1;
        cfg_mode = m;
        step(1);
        cfg_we = 1'b0;
    endtask

    // Monitor: pops expected items as their cycle arrives
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
            exp_t e;
            logic [3:0] fl_act;
            e = exp_q.pop_front();
            fl_act = {pll_active, tbase_active, snoop_active, pll_bypass_ok};
            checks++;
            if (e.at != cyc || state_o !== e.st || qreq !== e.qr ||
                pd_pending !== e.pd || fl_act !== e.fl) begin
                errors++;
                $display("FAIL %s: cyc=%0d/%0d st=%0d/%0d qreq=%b/%b pd=%b/%b flags=%b/%b (actual/expected)",
                         e.tag, cyc, e.at, state_o, e.st, qreq, e.qr,
                         pd_pending, e.pd, fl_act, e.fl);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_at(1, 3'd0, 1'b0, 1'b0, FL_UP, "R1 reset");
        step(3);

        // R2 request with nothing enabled is dropped
        write_cfg(3'b000);
        pd_set = 1'b1;
        expect_at(1, 3'd0, 1'b0, 1'b1, FL_UP, "R2 request seen");
        expect_at(2, 3'd0, 1'b0, 1'b0, FL_UP, "R2 request dropped");
        expect_at(4, 3'd0, 1'b0, 1'b0, FL_UP, "R2 still run");
        step(1);
        pd_set = 1'b0;
        step(5);

        // R4 doze, then R9 wake
        write_cfg(3'b001);
        pd_set = 1'b1;
        expect_at(1, 3'd0, 1'b0, 1'b1, FL_UP, "R4 pending");
        expect_at(2, 3'd1, 1'b0, 1'b1, FL_UP, "R4 doze entered");
        step(1);
        pd_set = 1'b0;
        step(4);
        wake = 1'b1;
        expect_at(1, 3'd0, 1'b0, 1'b0, FL_UP, "R9 wake from doze");
        step(1);
        wake = 0;
        step(3);

        // R5 nap handshake, R6 delay with one-cycle ack, R7 nap flags
        write_cfg(3'b010);
        pd_set = 1'b1;
        expect_at(2, 3'd2, 1'b1, 1'b1, FL_UP, "R5 nap_wait with qreq");
        step(1);
        pd_set = 1'b0;
        step(3);
        qack = 1'b1;
        expect_at(8, 3'd2, 1'b1, 1'b1, FL_UP, "R6 not yet in nap");
        expect_at(9, 3'd3, 1'b1, 1'b1, FL_NAP, "R7 nap entered");
        step(1);
        qack = 1'b0;
        step(10);
        wake = 1'b1;
        expect_at(1, 3'd0, 1'b0, 1'b0, FL_UP, "R9 wake from nap");
        step(1);
        wake = 1'b0;
        step(3);

        // R3 all enabled picks sleep; R8 sleep flags
        write_cfg(3'b111);
        pd_set = 1'b1;
        expect_at(2, 3'd4, 1'b1, 1'b1, FL_UP, "R3 sleep has priority");
        step(1);
        pd_set = 1'b0;
        step(2);
        qack = 1'b1;
        expect_at(8, 3'd4, 1'b1, 1'b1, FL_UP, "R6 sleep delay");
        expect_at(9, 3'd5, 1'b1, 1'b1, FL_SLEEP, "R8 sleep entered");
        step(12);
        qack = 1'b0;
        wake = 1'b1;
        expect_at(1, 3'd0, 1'b0, 1'b0, FL_UP, "R9 wake from sleep");
        step(1);
        wake = 1'b0;
        step(3);

        // R3 nap over doze; R10 timeout without ack
        write_cfg(3'b011);
        pd_set = 1'b1;
        expect_at(2, 3'd2, 1'b1, 1'b1, FL_UP, "R3 nap over doze");
        expect_at(65, 3'd2, 1'b1, 1'b1, FL_UP, "R10 before timeout");
        expect_at(66, 3'd0, 1'b0, 1'b0, FL_UP, "R10 abandoned");
        step(1);
        pd_set = 1'b0;
        step(70);

        // R9 wake during sleep_wait
        write_cfg(3'b100);
        pd_set = 1'b1;
        expect_at(2, 3'd4, 1'b1, 1'b1, FL_UP, "R5 sleep_wait with qreq");
        step(1);
        pd_set = 1'b0;
        step(2);
        wake = 1'b1;
        expect_at(1, 3'd0, 1'b0, 1'b0, FL_UP, "R9 wake in wait");
        expect_at(4, 3'd0, 1'b0, 1'b0, FL_UP, "R11 stays run");
        step(1);
        wake = 1'b0;
        step(6);

        if (exp_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: %0d items left (actual) vs 0 (expected)", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule